// File: doc/BRIEF.md
# Processor Sleep Sequencer

This block decides when a processor core may stop its clock and when it may run again. Software arms it through one memory-mapped control word. The core then takes the dedicated wake-capable interrupt while the enable bit is set. An idle instruction executed inside that handler puts the processor to sleep. A return-from-interrupt executed before any idle cancels the attempt. While asleep, the block gates the core clock and raises an acknowledge output. It can also switch off the crystal oscillator.

A low-to-high transition on the asynchronous wake flag input ends sleep, and so does hardware reset. If the oscillator was switched off, the core clock stays gated for a fixed restart interval so the crystal can settle. On exit the block pulses one of two outputs for one cycle: one tells the core to resume where it stopped, the other requests a soft reset. Which pulse fires depends on a control bit.

The control word sits at address `REG_ADDR` (default 0x3FEF). The four sleep fields occupy bits 15 down to 12, and every other bit reads as zero.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, `pd_ack` and `osc_off` are 0 and `core_clk_en` is 1.
- R2: A write to `REG_ADDR` stores bit 15 (oscillator off while asleep), bit 13 (sleep enable) and bit 12 (1 = soft reset on wake, 0 = resume). Bits 11..0 read as 0, bit 14 ignores writes, and any other address reads 0x0000.
- R3: Bit 14 of the control word shows the synchronized wake flag when bit 13 is 1 and reads 0 when bit 13 is 0.
- R4: After `irq_taken` with bit 13 set, an `idle_exec` pulse enters sleep. In the cycle after that edge, `pd_ack` is 1 and `core_clk_en` is 0.
- R5: An `irq_taken` that arrives while bit 13 is 0 does not arm the block, and a later `idle_exec` leaves `pd_ack` at 0.
- R6: An `rti_exec` while armed cancels the sequence, and a later `idle_exec` has no effect.
- R7: While asleep, `osc_off` equals bit 15. It is 0 at all other times.
- R8: Only a 0-to-1 transition of `flag_in` seen while asleep ends sleep. A flag already high at entry keeps the block asleep, and edges seen while awake change nothing.
- R9: If bit 15 is 1, the block spends exactly `WAKE_CYCLES` cycles (default 4096) after the synchronized edge with `pd_ack` at 1, `osc_off` at 0 and `core_clk_en` at 0, and only then releases the core. If bit 15 is 0, the core is released in the cycle after the synchronized edge.
- R10: On release the block pulses `resume_pulse` for one cycle when bit 12 is 0, or `soft_rst_pulse` for one cycle when bit 12 is 1. It never pulses both.
- R11: Asserting `rst_n` low while asleep ends sleep at once and restores the R1 state.
- R12: If bit 13 has been cleared by the time `idle_exec` arrives while armed, the block returns to running and does not sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_addr | input | ADDR_W | Data-memory address of the access |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Control word read data, 0 when address misses |
| irq_taken | input | 1 | Core vectored to the wake-capable interrupt handler |
| idle_exec | input | 1 | Core executed an idle instruction |
| rti_exec | input | 1 | Core executed a return from interrupt |
| flag_in | input | 1 | Asynchronous wake flag pin |
| pd_ack | output | 1 | High while the processor is asleep |
| osc_off | output | 1 | Disables the crystal oscillator |
| core_clk_en | output | 1 | Core clock gate enable |
| resume_pulse | output | 1 | One-cycle request to continue execution |
| soft_rst_pulse | output | 1 | One-cycle request for a soft reset |

## Verification
A state machine stuck in sleep shows `pd_ack` high and the core clock gated indefinitely. A machine that never arms leaves `pd_ack` low one cycle after the idle pulse. A wrong restart count moves the falling edge of `pd_ack` away from exactly `WAKE_CYCLES` cycles after the synchronized flag edge, and the bench checks one cycle before and at that boundary. A swapped wake-action bit fires the wrong pulse in the single release cycle. A faulty edge detector either wakes on a flag that was already high or misses a clean edge, both visible within three cycles.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
   typedef enum logic [2:0] {
      ST_RUN   = 3'd0,
      ST_ARMED = 3'd1,
      ST_DOWN  = 3'd2,
      ST_WAKE  = 3'd3,
      ST_EXIT  = 3'd4
   } sleep_state_e;

   localparam int CTRL_W   = 16;
   localparam int BIT_XTAL = 15;
   localparam int BIT_FLAG = 14;
   localparam int BIT_EN   = 13;
   localparam int BIT_ACT  = 12;
endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   initial begin
      if (STAGES < 2) $error("pwr_flag_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign level = chain[STAGES-1];
   assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
   import pwr_sleep_pkg::*;
#(
   parameter int          ADDR_W   = 14,
   parameter logic [13:0] REG_ADDR = 14'h3FEF,
   parameter bit          HAS_XTAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              flag_level,
   output logic [CTRL_W-1:0] rdata,
   output logic              xtal_dis,
   output logic              sleep_en,
   output logic              wake_rst
);
   initial begin
      if (ADDR_W < 14) $error("pwr_ctrl_reg: ADDR_W too small for REG_ADDR");
   end

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

   logic hit;
   logic xtal_q, en_q, act_q;

   assign hit = (addr == HIT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         act_q <= 1'b0;
      end else if (wr && hit) begin
         en_q  <= wdata[BIT_EN];
         act_q <= wdata[BIT_ACT];
      end
   end

   generate
      if (HAS_XTAL) begin : g_xtal
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         xtal_q <= 1'b0;
            else if (wr && hit) xtal_q <= wdata[BIT_XTAL];
         end
      end else begin : g_no_xtal
         assign xtal_q = 1'b0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[BIT_XTAL] = xtal_q;
         rdata[BIT_FLAG] = en_q & flag_level;
         rdata[BIT_EN]   = en_q;
         rdata[BIT_ACT]  = act_q;
      end
   end

   assign xtal_dis = xtal_q;
   assign sleep_en = en_q;
   assign wake_rst = act_q;
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
   parameter int WAKE_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic done
);
   initial begin
      if (WAKE_CYCLES < 2) $error("pwr_wake_timer: WAKE_CYCLES must be at least 2");
   end

   localparam int              CNT_W    = $clog2(WAKE_CYCLES);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAKE_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= LOAD_VAL;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
   import pwr_sleep_pkg::*;
#(
   parameter int          ADDR_W      = 14,
   parameter logic [13:0] REG_ADDR    = 14'h3FEF,
   parameter int          WAKE_CYCLES = 4096,
   parameter int          SYNC_STAGES = 2,
   parameter bit          HAS_XTAL    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              irq_taken,
   input  logic              idle_exec,
   input  logic              rti_exec,
   input  logic              flag_in,
   output logic              pd_ack,
   output logic              osc_off,
   output logic              core_clk_en,
   output logic              resume_pulse,
   output logic              soft_rst_pulse
);
   sleep_state_e state_q, state_d;
   logic flag_level, flag_rise;
   logic xtal_dis, sleep_en, wake_rst;
   logic timer_load, timer_done;

   pwr_flag_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(flag_in),
      .level(flag_level), .rise(flag_rise)
   );

   pwr_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .HAS_XTAL(HAS_XTAL)) u_reg (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
      .flag_level(flag_level), .rdata(reg_rdata),
      .xtal_dis(xtal_dis), .sleep_en(sleep_en), .wake_rst(wake_rst)
   );

   assign timer_load = (state_q == ST_DOWN) && flag_rise && sleep_en && xtal_dis;

   generate
      if (HAS_XTAL) begin : g_timer
         pwr_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
            .clk(clk), .rst_n(rst_n), .load(timer_load),
            .run(state_q == ST_WAKE), .done(timer_done)
         );
      end else begin : g_no_timer
         assign timer_done = 1'b1;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN:   if (irq_taken && sleep_en) state_d = ST_ARMED;
         ST_ARMED: begin
            if (rti_exec)       state_d = ST_RUN;
            else if (idle_exec) state_d = sleep_en ? ST_DOWN : ST_RUN;
         end
         ST_DOWN:  if (flag_rise && sleep_en) state_d = xtal_dis ? ST_WAKE : ST_EXIT;
         ST_WAKE:  if (timer_done) state_d = ST_EXIT;
         ST_EXIT:  state_d = ST_RUN;
         default:  state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   logic asleep;
   assign asleep         = (state_q == ST_DOWN) || (state_q == ST_WAKE);
   assign pd_ack         = asleep && sleep_en;
   assign core_clk_en    = !asleep;
   assign osc_off        = (state_q == ST_DOWN) && xtal_dis;
   assign resume_pulse   = (state_q == ST_EXIT) && !wake_rst;
   assign soft_rst_pulse = (state_q == ST_EXIT) && wake_rst;
endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk #(
   parameter int          ADDR_W   = 14,
   parameter logic [13:0] REG_ADDR = 14'h3FEF
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [15:0]       reg_rdata,
   input logic              idle_exec,
   input logic              pd_ack,
   input logic              osc_off,
   input logic              core_clk_en,
   input logic              resume_pulse,
   input logic              soft_rst_pulse
);
   // R4
   ack_gates_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_ack |-> !core_clk_en);

   // R7
   osc_only_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osc_off |-> !core_clk_en);

   // R10
   single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(resume_pulse && soft_rst_pulse));

   // R10
   resume_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_pulse |=> !resume_pulse);

   // R10
   softrst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_pulse |=> !soft_rst_pulse);

   // R4
   entry_by_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pd_ack) |-> ($past(idle_exec) || $past(reg_wr)));

   // R3
   flag_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(REG_ADDR) && !reg_rdata[13]) |-> !reg_rdata[14]);

   // R2
   miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != ADDR_W'(REG_ADDR)) |-> (reg_rdata == 16'h0000));
endmodule

bind pwr_sleep_ctrl pwr_sleep_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_rdata(reg_rdata), .idle_exec(idle_exec), .pd_ack(pd_ack),
   .osc_off(osc_off), .core_clk_en(core_clk_en),
   .resume_pulse(resume_pulse), .soft_rst_pulse(soft_rst_pulse)
);

// File: tb/pwr_sleep_ctrl_test.sv
module pwr_sleep_ctrl_test;
   localparam int          ADDR_W = 14;
   localparam logic [13:0] RA     = 14'h3FEF;
   localparam int          NWAKE  = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = RA;
   logic reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq_taken = 1'b0, idle_exec = 1'b0, rti_exec = 1'b0, flag_in = 1'b0;
   logic pd_ack, osc_off, core_clk_en, resume_pulse, soft_rst_pulse;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pwr_sleep_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_taken(irq_taken),
      .idle_exec(idle_exec), .rti_exec(rti_exec), .flag_in(flag_in),
      .pd_ack(pd_ack), .osc_off(osc_off), .core_clk_en(core_clk_en),
      .resume_pulse(resume_pulse), .soft_rst_pulse(soft_rst_pulse)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // {pd_ack, osc_off, core_clk_en, resume_pulse, soft_rst_pulse}
   function automatic int outs();
      return {27'd0, pd_ack, osc_off, core_clk_en, resume_pulse, soft_rst_pulse};
   endfunction

   task automatic wr_reg(input logic [15:0] v);
      reg_addr = RA; reg_wdata = v; reg_wr = 1'b1;
      tick();
      reg_wr = 1'b0;
   endtask

   task automatic pulse_irq();  irq_taken = 1'b1; tick(); irq_taken = 1'b0; endtask
   task automatic pulse_idle(); idle_exec = 1'b1; tick(); idle_exec = 1'b0; endtask
   task automatic pulse_rti();  rti_exec  = 1'b1; tick(); rti_exec  = 1'b0; endtask

   task automatic do_reset();
      rst_n = 1'b0; flag_in = 1'b0; tick(2); rst_n = 1'b1; tick();
   endtask

   task automatic t_reset();
      do_reset();
      reg_addr = RA; #1;
      check(reg_rdata == 16'h0000, "R1 ctrl word", reg_rdata, 0);
      check(outs() == 5'b00100, "R1 outputs", outs(), 5'b00100);
   endtask

   task automatic t_register();
      wr_reg(16'hFFFF); #1;
      check(reg_rdata == 16'hB000, "R2 write all ones", reg_rdata, 16'hB000);
      reg_addr = 14'h0123; #1;
      check(reg_rdata == 16'h0000, "R2 other address", reg_rdata, 0);
      reg_addr = RA;
      wr_reg(16'h9000); #1;
      check(reg_rdata == 16'h9000, "R2 enable clear", reg_rdata, 16'h9000);
      wr_reg(16'h0000);
   endtask

   task automatic t_flag_bit();
      flag_in = 1'b1; tick(3);
      check(reg_rdata[14] == 1'b0, "R3 flag masked", reg_rdata[14], 0);
      wr_reg(16'h2000); #1;
      check(reg_rdata[14] == 1'b1, "R3 flag visible", reg_rdata[14], 1);
      flag_in = 1'b0; tick(3);
      check(reg_rdata[14] == 1'b0, "R3 flag low", reg_rdata[14], 0);
      wr_reg(16'h0000);
   endtask

   task automatic t_no_arm();
      pulse_irq(); pulse_idle(); tick();
      check(pd_ack == 1'b0 && core_clk_en, "R5 idle without enable", outs(), 5'b00100);
   endtask

   task automatic t_abort();
      wr_reg(16'h2000);
      pulse_irq(); tick(3); pulse_rti(); pulse_idle();
      check(pd_ack == 1'b0 && core_clk_en, "R6 rti cancels", outs(), 5'b00100);
   endtask

   task automatic t_enable_dropped();
      wr_reg(16'h2000);
      pulse_irq(); wr_reg(16'h0000); pulse_idle();
      check(pd_ack == 1'b0 && core_clk_en, "R12 enable dropped", outs(), 5'b00100);
      pulse_idle();
      check(pd_ack == 1'b0, "R12 back to run", pd_ack, 0);
   endtask

   // sleep with running oscillator, resume action
   task automatic t_fast_wake();
      wr_reg(16'h2000);
      pulse_irq(); tick(2); pulse_idle();
      check(outs() == 5'b10000, "R4 asleep", outs(), 5'b10000);
      check(osc_off == 1'b0, "R7 osc kept", osc_off, 0);
      tick(20);
      check(pd_ack == 1'b1, "R8 stays asleep", pd_ack, 1);
      flag_in = 1'b1; tick(2);
      check(pd_ack == 1'b1, "R8 before sync edge", pd_ack, 1);
      tick();
      check(outs() == 5'b00110, "R10 resume pulse", outs(), 5'b00110);
      tick();
      check(outs() == 5'b00100, "R10 pulse one cycle", outs(), 5'b00100);
      flag_in = 1'b0; tick(3);
   endtask

   // flag already high at entry must not wake
   task automatic t_held_flag();
      wr_reg(16'h2000);
      flag_in = 1'b1; tick(3);
      pulse_irq(); pulse_idle(); tick(10);
      check(pd_ack == 1'b1, "R8 level does not wake", pd_ack, 1);
      flag_in = 1'b0; tick(4);
      check(pd_ack == 1'b1, "R8 fall does not wake", pd_ack, 1);
      flag_in = 1'b1; tick(3);
      check(outs() == 5'b00110, "R8 rise wakes", outs(), 5'b00110);
      flag_in = 1'b0; tick(3);
   endtask

   // oscillator off, restart delay, soft reset action
   task automatic t_slow_wake();
      wr_reg(16'hB000);
      pulse_irq(); pulse_idle();
      check(outs() == 5'b11000, "R7 osc off asleep", outs(), 5'b11000);
      flag_in = 1'b1; tick(3);
      check(outs() == 5'b10000, "R9 restart window", outs(), 5'b10000);
      tick(NWAKE - 1);
      check(pd_ack == 1'b1 && !core_clk_en, "R9 last wait cycle", outs(), 5'b10000);
      tick();
      check(outs() == 5'b00101, "R10 soft reset pulse", outs(), 5'b00101);
      tick();
      check(outs() == 5'b00100, "R9 released", outs(), 5'b00100);
      flag_in = 1'b0; tick(3);
   endtask

   task automatic t_reset_asleep();
      wr_reg(16'hA000);
      pulse_irq(); pulse_idle();
      check(pd_ack == 1'b1, "R11 asleep before reset", pd_ack, 1);
      rst_n = 1'b0; #3;
      check(outs() == 5'b00100, "R11 reset exits", outs(), 5'b00100);
      check(reg_rdata == 16'h0000, "R11 ctrl cleared", reg_rdata, 0);
      tick(); rst_n = 1'b1; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_register();
      t_flag_bit();
      t_no_arm();
      t_abort();
      t_enable_dropped();
      t_fast_wake();
      t_held_flag();
      t_slow_wake();
      t_reset_asleep();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule